// File: doc/BRIEF.md
# Timer Interrupt Router with Fixed Legacy Mapping

This block sits between a bank of three comparator timers and two interrupt fabrics: a 16-line legacy controller and a 24-pin advanced controller. Each cycle it takes the match pulses of the timers and turns each enabled one into a one-cycle edge pulse on the interrupt line that the timer is configured for. Timers are either routed by their own 5-bit route field, which is checked against a per-timer capability mask, or, when the legacy mode bit is on, timers 0 and 1 use a fixed mapping that drives both fabrics at once.

Deliveries under the fixed mapping pass through a small per-line sequencer with four states. LN_IDLE means the line has never been raised. LN_HELD means the line stands asserted. There are two transient states: LN_DROP (line released, share count decremented) and LN_RAISE (line re-asserted, edge emitted when the share count is zero). The transitions are: LN_IDLE to LN_DROP on a request, LN_HELD to LN_DROP on a request, LN_DROP to LN_RAISE always, and LN_RAISE to LN_HELD always. With no request, LN_IDLE and LN_HELD stay where they are. Because the line is always released before it is raised again, every delivery gives a fresh rising edge. Route checks, level-trigger configuration and a sticky error flag make up the rest of the block. There is also a mask output that silences channel 0 of a legacy interval timer while that timer's role is taken over.

Top module: `tmr_irq_router`

## Requirements
- R1: With `legacy_mode`=1, a delivery from timer 0 pulses `pic_edge[0]` and `apic_edge[2]` together for one cycle. If the match is sampled at clock edge k, the pulse is visible between edges k+1 and k+2.
- R2: With `legacy_mode`=1, a delivery from timer 1 pulses `pic_edge[8]` and `apic_edge[8]` together for one cycle, with the same timing as R1.
- R3: With `legacy_mode`=1, timer 2 still goes through its own route field, following R6 and R7.
- R4: Every fixed-mapping delivery runs LN_DROP then LN_RAISE, so it gives a new one-cycle edge even when the line is already held. A request that arrives while the line is in LN_DROP or LN_RAISE is merged into the delivery already running and gives no second edge.
- R5: Each fixed-mapping line keeps a share count that is cleared at reset. The count decrements, saturating at zero, when the line leaves LN_DROP, and increments when it leaves LN_RAISE. An edge is emitted in LN_RAISE only when the count is zero.
- R6: For a timer on its route field, the route value is the pin number (bits [5t+4:5t] of `route_sel` for timer t), and bit p of slice t of `route_cap` (bits [24t+23:24t]) allows pin p. A valid route pulses `apic_edge[route]` for one cycle, visible between edges k and k+1, and never touches `pic_edge`.
- R7: A routed delivery whose route is 24 or higher, or whose capability bit is clear, sends no pulse and sets `route_err`. `route_err` stays set until reset.
- R8: `pit_ch0_mask` is high exactly when `legacy_mode` and `tmr_en[0]` are both high.
- R9: An enabled timer that fires with its `tmr_level` bit set sets `route_err` and delivers nothing, in either mode.
- R10: A match pulse from a timer whose `tmr_en` bit is low is ignored.
- R11: Timers that fire in the same cycle are all served in that cycle, each on its own line.
- R12: During and right after reset, `pic_edge`, `apic_edge` and `route_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_fire | input | 3 | Match pulse per timer |
| tmr_en | input | 3 | Timer enable per timer |
| tmr_level | input | 3 | Level-trigger request per timer (unsupported, flagged) |
| legacy_mode | input | 1 | Fixed mapping for timers 0 and 1 |
| route_sel | input | 15 | 5-bit route field per timer |
| route_cap | input | 72 | 24-bit pin capability mask per timer |
| pic_edge | output | 16 | One-cycle edge per legacy controller line |
| apic_edge | output | 24 | One-cycle edge per advanced controller pin |
| pit_ch0_mask | output | 1 | Silences legacy interval timer channel 0 |
| route_err | output | 1 | Sticky configuration error |

## Verification
A sequencer stuck in LN_HELD or LN_DROP shows up as a missing legacy edge two cycles after the match. A sequencer that loops back to LN_RAISE shows up as a pulse wider than one cycle, seen at the third sample. A share count that wraps instead of saturating suppresses the very first edge after reset. A bad route decode shows up as the wrong `apic_edge` bit one cycle after the match, and a missed error case shows up in `route_err` within that same cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // timers that take part in the fixed legacy mapping
    localparam int unsigned LEG_TIMERS = 2;

    // fixed mapping: index = timer number
    localparam int unsigned LEG_PIC_LINE [LEG_TIMERS] = '{0, 8};
    localparam int unsigned LEG_APIC_PIN [LEG_TIMERS] = '{2, 8};

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_DROP  = 2'd1,
        LN_RAISE = 2'd2,
        LN_HELD  = 2'd3
    } line_state_e;

endpackage

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int APIC_PINS = 24,
    parameter int ROUTE_W   = 5
) (
    input  logic [ROUTE_W-1:0]   route_i,
    input  logic [APIC_PINS-1:0] cap_i,
    output logic [APIC_PINS-1:0] pin_o,
    output logic                 ok_o
);

    // a route beyond the pin range matches no pin, so it is invalid too
    always_comb begin
        for (int i = 0; i < APIC_PINS; i++) begin
            pin_o[i] = cap_i[i] && (route_i == ROUTE_W'(i));
        end
        ok_o = |pin_o;
    end

endmodule

// File: rtl/irq_line_seq.sv
module irq_line_seq
    import irq_route_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic edge_o
);

    line_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and share count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LN_IDLE, LN_HELD: begin
                if (req_i) state_d = LN_DROP;
            end
            LN_DROP: begin
                state_d = LN_RAISE;
                if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
            end
            LN_RAISE: begin
                state_d = LN_HELD;
                if (cnt_q != '1) cnt_d = cnt_q + CNT_W'(1);
            end
            default: state_d = LN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        edge_o = (state_q == LN_RAISE) && (cnt_q == '0);
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R4
    AST_EDGE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> ($past(state_q) == LN_DROP)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(1)); // R5

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
    import irq_route_pkg::*;
#(
    parameter int N_TMR     = 3,
    parameter int APIC_PINS = 24,
    parameter int PIC_LINES = 16,
    parameter int ROUTE_W   = 5,
    parameter int CNT_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_TMR-1:0]             tmr_fire,
    input  logic [N_TMR-1:0]             tmr_en,
    input  logic [N_TMR-1:0]             tmr_level,
    input  logic                         legacy_mode,
    input  logic [N_TMR*ROUTE_W-1:0]     route_sel,
    input  logic [N_TMR*APIC_PINS-1:0]   route_cap,
    output logic [PIC_LINES-1:0]         pic_edge,
    output logic [APIC_PINS-1:0]         apic_edge,
    output logic                         pit_ch0_mask,
    output logic                         route_err
);

    logic [APIC_PINS-1:0]  tmr_pins [N_TMR];
    logic [N_TMR-1:0]      route_ok;
    logic [N_TMR-1:0]      leg_use;
    logic [LEG_TIMERS-1:0] leg_req;
    logic [LEG_TIMERS-1:0] line_edge;
    logic [APIC_PINS-1:0]  apic_d, apic_pulse_q;
    logic                  err_hit;

    // per-timer route validation
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        irq_route_chk #(
            .APIC_PINS (APIC_PINS),
            .ROUTE_W   (ROUTE_W)
        ) u_chk (
            .route_i (route_sel[g*ROUTE_W +: ROUTE_W]),
            .cap_i   (route_cap[g*APIC_PINS +: APIC_PINS]),
            .pin_o   (tmr_pins[g]),
            .ok_o    (route_ok[g])
        );
        if (g < LEG_TIMERS) begin : g_leg
            assign leg_use[g] = legacy_mode;
        end else begin : g_own
            assign leg_use[g] = 1'b0;
        end
    end

    // delivery decision
    always_comb begin
        apic_d  = '0;
        err_hit = 1'b0;
        for (int t = 0; t < N_TMR; t++) begin
            if (tmr_fire[t] && tmr_en[t]) begin
                if (tmr_level[t])       err_hit = 1'b1;
                else if (leg_use[t])    ;
                else if (route_ok[t])   apic_d  = apic_d | tmr_pins[t];
                else                    err_hit = 1'b1;
            end
        end
        for (int l = 0; l < LEG_TIMERS; l++) begin
            leg_req[l] = legacy_mode && tmr_fire[l] && tmr_en[l] && !tmr_level[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apic_pulse_q <= '0;
            route_err    <= 1'b0;
        end else begin
            apic_pulse_q <= apic_d;
            route_err    <= route_err | err_hit;
        end
    end

    // fixed-mapping line sequencers
    for (genvar l = 0; l < LEG_TIMERS; l++) begin : g_line
        irq_line_seq #(
            .CNT_W (CNT_W)
        ) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (leg_req[l]),
            .edge_o (line_edge[l])
        );
    end

    // outputs
    always_comb begin
        pic_edge  = '0;
        apic_edge = apic_pulse_q;
        for (int l = 0; l < LEG_TIMERS; l++) begin
            pic_edge[LEG_PIC_LINE[l]]  = pic_edge[LEG_PIC_LINE[l]]  | line_edge[l];
            apic_edge[LEG_APIC_PIN[l]] = apic_edge[LEG_APIC_PIN[l]] | line_edge[l];
        end
        pit_ch0_mask = legacy_mode && tmr_en[0];
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |=> route_err); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(route_err) |-> $past(|(tmr_fire & tmr_en))); // R9
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|apic_pulse_q) |-> $past(|(tmr_fire & tmr_en & ~tmr_level))); // R10
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(apic_pulse_q) <= N_TMR); // R11

endmodule

// File: tb/tmr_irq_router_bench.sv
`timescale 1ns/1ps
module tmr_irq_router_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  tmr_fire, tmr_en, tmr_level;
    logic        legacy_mode;
    logic [14:0] route_sel;
    logic [71:0] route_cap;
    logic [15:0] pic_edge;
    logic [23:0] apic_edge;
    logic        pit_ch0_mask, route_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tmr_irq_router u_tmr_irq_router (
        .clk (clk), .rst_n (rst_n),
        .tmr_fire (tmr_fire), .tmr_en (tmr_en), .tmr_level (tmr_level),
        .legacy_mode (legacy_mode), .route_sel (route_sel), .route_cap (route_cap),
        .pic_edge (pic_edge), .apic_edge (apic_edge),
        .pit_ch0_mask (pit_ch0_mask), .route_err (route_err)
    );

    typedef struct packed {
        logic        leg;
        logic [2:0]  en;
        logic [2:0]  lvl;
        logic [2:0]  fire;
        logic [4:0]  r0;
        logic [4:0]  r1;
        logic [4:0]  r2;
        logic        pit;
        logic [23:0] a1;
        logic [23:0] a2;
        logic [15:0] p2;
        logic        err;
    } vec_t;

    // pin 0 is not allowed for any timer
    localparam logic [23:0] CAP = 24'hFF_FFFE;
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'b001, 3'b000, 3'b001, 5'd3, 5'd3,  5'd3,  1'b1, 24'h0,      24'h000004, 16'h0001, 1'b0},
        '{1'b1, 3'b010, 3'b000, 3'b010, 5'd3, 5'd3,  5'd3,  1'b0, 24'h0,      24'h000100, 16'h0100, 1'b0},
        '{1'b1, 3'b100, 3'b000, 3'b100, 5'd3, 5'd3,  5'd5,  1'b0, 24'h000020, 24'h0,      16'h0,    1'b0},
        '{1'b0, 3'b001, 3'b000, 3'b001, 5'd3, 5'd3,  5'd3,  1'b0, 24'h000008, 24'h0,      16'h0,    1'b0},
        '{1'b0, 3'b001, 3'b000, 3'b001, 5'd0, 5'd3,  5'd3,  1'b0, 24'h0,      24'h0,      16'h0,    1'b1},
        '{1'b0, 3'b010, 3'b000, 3'b010, 5'd3, 5'd25, 5'd3,  1'b0, 24'h0,      24'h0,      16'h0,    1'b1},
        '{1'b0, 3'b100, 3'b100, 3'b100, 5'd3, 5'd3,  5'd4,  1'b0, 24'h0,      24'h0,      16'h0,    1'b1},
        '{1'b0, 3'b000, 3'b000, 3'b111, 5'd3, 5'd7,  5'd9,  1'b0, 24'h0,      24'h0,      16'h0,    1'b0},
        '{1'b0, 3'b111, 3'b000, 3'b111, 5'd3, 5'd7,  5'd9,  1'b0, 24'h000288, 24'h0,      16'h0,    1'b0},
        '{1'b1, 3'b111, 3'b000, 3'b111, 5'd3, 5'd7,  5'd12, 1'b1, 24'h001000, 24'h000104, 16'h0101, 1'b0},
        '{1'b1, 3'b001, 3'b001, 3'b001, 5'd3, 5'd3,  5'd3,  1'b1, 24'h0,      24'h0,      16'h0,    1'b1},
        '{1'b0, 3'b111, 3'b000, 3'b110, 5'd3, 5'd24, 5'd24, 1'b0, 24'h0,      24'h0,      16'h0,    1'b1},
        '{1'b0, 3'b100, 3'b000, 3'b100, 5'd3, 5'd3,  5'd23, 1'b0, 24'h800000, 24'h0,      16'h0,    1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        tmr_fire = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one-cycle match, then look at the three cycles after it
    task automatic pulse_fire(input logic [2:0] f);
        tmr_fire = f;
        @(negedge clk);
        tmr_fire = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; tmr_fire = '0; tmr_en = '0; tmr_level = '0;
        legacy_mode = 1'b0; route_sel = '0; route_cap = {CAP, CAP, CAP};

        // R12: outputs quiet while reset is held, even with a match pending
        tmr_en = 3'b111; route_sel = {5'd4, 5'd4, 5'd4}; tmr_fire = 3'b111;
        @(negedge clk); @(negedge clk);
        chk("R12 apic in reset", 32'(apic_edge), 32'h0);
        chk("R12 pic in reset",  32'(pic_edge),  32'h0);
        chk("R12 err in reset",  32'(route_err), 32'h0);
        tmr_fire = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 apic after reset", 32'(apic_edge), 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            legacy_mode = TBL[i].leg;
            tmr_en      = TBL[i].en;
            tmr_level   = TBL[i].lvl;
            route_sel   = {TBL[i].r2, TBL[i].r1, TBL[i].r0};
            do_reset();
            pulse_fire(TBL[i].fire);
            chk("R3 R6 R10 R11 routed pulse", 32'(apic_edge), 32'(TBL[i].a1));
            chk("R6 no legacy edge yet",      32'(pic_edge),  32'h0);
            chk("R8 pit mask",                32'(pit_ch0_mask), 32'(TBL[i].pit));
            @(negedge clk);
            chk("R1 R2 R11 legacy apic edge", 32'(apic_edge), 32'(TBL[i].a2));
            chk("R1 R2 legacy pic edge",      32'(pic_edge),  32'(TBL[i].p2));
            chk("R7 R9 error flag",           32'(route_err), 32'(TBL[i].err));
            @(negedge clk);
            chk("R4 pulses end apic", 32'(apic_edge), 32'h0);
            chk("R4 pulses end pic",  32'(pic_edge),  32'h0);
        end

        // R4 R5: first edge after reset, then redelivery on a held line
        legacy_mode = 1'b1; tmr_en = 3'b001; tmr_level = '0;
        do_reset();
        pulse_fire(3'b001);
        @(negedge clk);
        chk("R5 first edge after reset", 32'(pic_edge[0]), 32'h1);
        repeat (3) @(negedge clk);
        pulse_fire(3'b001);
        @(negedge clk);
        chk("R4 held line pic edge",  32'(pic_edge[0]),  32'h1);
        chk("R4 held line apic edge", 32'(apic_edge[2]), 32'h1);

        // R4: two-cycle request merges into one edge
        repeat (3) @(negedge clk);
        tmr_fire = 3'b001;
        @(negedge clk);
        @(negedge clk);
        tmr_fire = '0;
        chk("R4 merged edge present", 32'(pic_edge[0]), 32'h1);
        @(negedge clk);
        chk("R4 merged no second a", 32'(pic_edge[0]), 32'h0);
        @(negedge clk);
        chk("R4 merged no second b", 32'(pic_edge[0]), 32'h0);

        // R7: error stays set, later valid route still delivers
        legacy_mode = 1'b0; tmr_en = 3'b001; route_sel = {5'd3, 5'd3, 5'd0};
        do_reset();
        pulse_fire(3'b001);
        route_sel = {5'd3, 5'd3, 5'd6};
        pulse_fire(3'b001);
        chk("R7 later valid pulse", 32'(apic_edge), 32'h40);
        chk("R7 error sticky",      32'(route_err), 32'h1);
        repeat (3) @(negedge clk);
        chk("R7 error still sticky", 32'(route_err), 32'h1);

        // R8: mask follows mode and timer 0 enable
        legacy_mode = 1'b1; tmr_en = 3'b001; #1;
        chk("R8 mask on", 32'(pit_ch0_mask), 32'h1);
        tmr_en = 3'b110; #1;
        chk("R8 mask off by enable", 32'(pit_ch0_mask), 32'h0);
        legacy_mode = 1'b0; tmr_en = 3'b111; #1;
        chk("R8 mask off by mode", 32'(pit_ch0_mask), 32'h0);

        summary();
    end

endmodule